// File: doc/BRIEF.md
# Interleaved Flash Program Sequencer

This block is a host-side controller that programs a register-mapped NAND flash part holding two dies. Each die is written through a two-plane cache program, and the dies are interleaved. Every page is handed to the block as a job. The job carries a die select, a buffer select, a block number, a page number and a flag that marks it as the final page of the die. The block turns each job into the correct series of 16-bit register accesses on a simple synchronous bus that uses request and acknowledge. Between the register writes it asks an external data mover to fill the device buffer.

The sequencer keeps a small record for each die. The record notes whether the die has already taken input, and whether its final two-plane command has been issued and is waiting for its partner. From this record it decides whether to wait for the die to become ready before writing. It also refuses jobs that would break the pairing of final commands. Once both final commands are out, it collects the program result of each die. Every job ends with a one-cycle done pulse and a status vector.

Top module: `ilv_prog_seq`

## Requirements
- R1: After reset, `done`, `bus_req` and `xfer_req` are low, and `job_ready` is high.
- R2: An accepted job with an even block produces this access order. First comes a write of 0xF100 with data = die·0x8000 + block. Then comes a write of 0xF101 with data = buffer·0x8000, then a write of 0xF107 with data = page·4 (sector field 00), then a write of 0xF200 with data 0x0800 (buffer sector 1000b in bits 11:8, count 00b in bits 1:0). One data transfer handshake follows, then the command write to 0xF220. The bus and the transfer request are never active together.
- R3: The 0xF101 write of a job always completes before that job raises `xfer_req`.
- R4: A job whose block number is odd ends with status bit 0 set, and it causes no bus access and no transfer.
- R5: The command written to 0xF220 is 0x007F for a job with `job_final` low and 0x007D for a job with `job_final` high.
- R6: On a die's first job, no poll is made. On later jobs, 0xF241 is read after the 0xF100 write until the value 0x8040 is returned. After that, 0x0000 is written to 0xF241, unless `auto_clr` is high, in which case the clear is skipped.
- R7: After a 0x007F command, 0xF240 is read once. Status bit 3 reports read bit 4 (plane 1, previous page). Status bit 4 reports read bit 2 (plane 2, previous page).
- R8: While one die has a final command outstanding, any job other than a final job for the other die is refused. The refusal sets status bit 1 and causes no bus access.
- R9: The final command for the second die starts a close-out, first for die 0 and then for die 1. Each die gets a write of 0xF100 with data = die·0x8000, a poll of 0xF241 with the clear rule of R6, and a read of 0xF240. Read bit 10 goes to status bit 5 for die 0 and status bit 6 for die 1. Afterwards both dies count as never having taken input.
- R10: If POLL_MAX consecutive poll reads return a value other than 0x8040, the job ends with status bit 2 set, and the state of both dies is reset to never having taken input.
- R11: Once `bus_req` is raised, it stays high and its address, direction and data stay fixed until `bus_ack`. It is low in the cycle after the acknowledge.
- R12: `done` is high for exactly one cycle per accepted job. Jobs are accepted only while `job_ready` is high, and nothing is requested on the bus during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_clr | input | 1 | Device clears its interrupt register itself; skip the clear write |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Sequencer idle, job taken on this edge if valid |
| job_die | input | 1 | Target die |
| job_buf | input | 1 | Device buffer select |
| job_block | input | BLK_W | Block number (must be even) |
| job_page | input | PG_W | Page number |
| job_final | input | 1 | Last two-plane page for this die |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Register address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transaction complete |
| xfer_req | output | 1 | Request to the data mover to fill the buffer |
| xfer_done | input | 1 | Data mover finished |
| done | output | 1 | Job finished pulse |
| status | output | 7 | Bit 0 odd block, 1 refused, 2 timeout, 3/4 plane 1/2 previous error, 5/6 die 0/1 program error |

## Verification
The bench looks for several likely mistakes. A design that always polls, or never polls, a die would show up in the access log on the first job after a close-out and on the first job after a timeout. In that log the poll either appears or vanishes when it should not. The timeout boundary is tested one read below and exactly at POLL_MAX, so an off-by-one counter ends a good job or lets a bad one finish. Refused and odd-block jobs must leave the log empty. All four combinations of the two plane bits and of the two die error bits are swept, so a swapped bit or a swapped die shows up as the wrong status.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam logic [15:0] A_DIEBLK  = 16'hF100;
  localparam logic [15:0] A_BUFSEL  = 16'hF101;
  localparam logic [15:0] A_PGSEC   = 16'hF107;
  localparam logic [15:0] A_BUFSEC  = 16'hF200;
  localparam logic [15:0] A_CMD     = 16'hF220;
  localparam logic [15:0] A_STAT    = 16'hF240;
  localparam logic [15:0] A_INT     = 16'hF241;

  localparam logic [15:0] INT_READY  = 16'h8040;
  localparam logic [15:0] CMD_CACHE  = 16'h007F;
  localparam logic [15:0] CMD_FINAL  = 16'h007D;
  localparam logic [15:0] BUFSEC_VAL = 16'h0800;

  localparam int ST_W   = 7;
  localparam int ST_ODD = 0;
  localparam int ST_SEQ = 1;
  localparam int ST_TMO = 2;
  localparam int ST_P1  = 3;
  localparam int ST_P2  = 4;
  localparam int ST_E0  = 5;
  localparam int ST_E1  = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_EVAL, S_ISSUE, S_WAIT, S_XFER, S_DONE
  } fsm_e;

  typedef enum logic [3:0] {
    ST_F100, ST_POLL, ST_CLR, ST_F101, ST_F107, ST_F200, ST_CMD, ST_STAT,
    ST_FSEL, ST_FPOLL, ST_FCLR, ST_FSTAT
  } step_e;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [15:0] data;
  } bus_op_t;
endpackage

// File: rtl/ilv_rst_sync.sv
module ilv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/ilv_bus_engine.sv
module ilv_bus_engine
  import ilv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  bus_op_t     op,
  output logic        bus_req,
  output logic        bus_we,
  output logic [15:0] bus_addr,
  output logic [15:0] bus_wdata,
  input  logic [15:0] bus_rdata,
  input  logic        bus_ack,
  output logic        done,
  output logic [15:0] rdata
);
  logic        req_d, done_d, ld;
  logic [15:0] rdata_d;

  always_comb begin
    req_d   = bus_req;
    done_d  = 1'b0;
    rdata_d = rdata;
    ld      = 1'b0;
    if (!bus_req && start) begin
      req_d = 1'b1;
      ld    = 1'b1;
    end else if (bus_req && bus_ack) begin
      req_d   = 1'b0;
      done_d  = 1'b1;
      rdata_d = bus_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      done      <= 1'b0;
      rdata     <= '0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      bus_req <= req_d;
      done    <= done_d;
      rdata   <= rdata_d;
      if (ld) begin
        bus_we    <= op.we;
        bus_addr  <= op.addr;
        bus_wdata <= op.we ? op.data : 16'h0000;
      end
    end
  end
endmodule

// File: rtl/ilv_poll_timer.sv
module ilv_poll_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/ilv_die_track.sv
module ilv_die_track #(
  parameter int NDIE = 2,
  localparam int DW  = (NDIE > 1) ? $clog2(NDIE) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   die,
  input  logic            set_start,
  input  logic            set_pend,
  input  logic            clr_all,
  output logic [NDIE-1:0] started,
  output logic [NDIE-1:0] pend
);
  for (genvar g = 0; g < NDIE; g++) begin : g_die
    logic start_d, pend_d;
    logic hit;

    assign hit = (die == DW'(g));

    always_comb begin
      start_d = started[g];
      pend_d  = pend[g];
      if (clr_all) begin
        start_d = 1'b0;
        pend_d  = 1'b0;
      end else begin
        if (set_start && hit) start_d = 1'b1;
        if (set_pend && hit)  pend_d  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        started[g] <= 1'b0;
        pend[g]    <= 1'b0;
      end else begin
        started[g] <= start_d;
        pend[g]    <= pend_d;
      end
    end
  end
endmodule

// File: rtl/ilv_prog_seq.sv
module ilv_prog_seq
  import ilv_pkg::*;
#(
  parameter int BLK_W    = 11,
  parameter int PG_W     = 6,
  parameter int POLL_MAX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_clr,
  input  logic             job_valid,
  output logic             job_ready,
  input  logic             job_die,
  input  logic             job_buf,
  input  logic [BLK_W-1:0] job_block,
  input  logic [PG_W-1:0]  job_page,
  input  logic             job_final,
  output logic             bus_req,
  output logic             bus_we,
  output logic [15:0]      bus_addr,
  output logic [15:0]      bus_wdata,
  input  logic [15:0]      bus_rdata,
  input  logic             bus_ack,
  output logic             xfer_req,
  input  logic             xfer_done,
  output logic             done,
  output logic [ST_W-1:0]  status
);
  localparam int NDIE = 2;

  logic srst_n;

  fsm_e  state_q, state_d;
  step_e step_q, step_d;
  logic  cdie_q, cdie_d;
  logic  jpoll_q, jpoll_d;
  logic [ST_W-1:0] stat_q, stat_d;

  logic             jdie_q, jbuf_q, jfin_q;
  logic [BLK_W-1:0] jblk_q;
  logic [PG_W-1:0]  jpg_q;
  logic             load_job;

  logic        eng_start, eng_done;
  logic [15:0] eng_rdata;
  bus_op_t     op;

  logic tmr_clr, tmr_inc, tmr_last;
  logic trk_start, trk_pend, trk_clr;
  logic [NDIE-1:0] started, pend;
  logic int_ok, refuse;

  ilv_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  ilv_bus_engine u_eng (
    .clk       (clk),
    .rst_n     (srst_n),
    .start     (eng_start),
    .op        (op),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack),
    .done      (eng_done),
    .rdata     (eng_rdata)
  );

  ilv_poll_timer #(.LIMIT(POLL_MAX)) u_tmr (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (tmr_clr),
    .inc   (tmr_inc),
    .last  (tmr_last)
  );

  ilv_die_track #(.NDIE(NDIE)) u_trk (
    .clk       (clk),
    .rst_n     (srst_n),
    .die       (jdie_q),
    .set_start (trk_start),
    .set_pend  (trk_pend),
    .clr_all   (trk_clr),
    .started   (started),
    .pend      (pend)
  );

  // bus operation for the current step
  always_comb begin
    op = '{we: 1'b0, addr: 16'h0000, data: 16'h0000};
    unique case (step_q)
      ST_F100: begin
        op.we   = 1'b1;
        op.addr = A_DIEBLK;
        op.data = (16'(jdie_q) << 15) | 16'(jblk_q);
      end
      ST_POLL, ST_FPOLL: op.addr = A_INT;
      ST_CLR, ST_FCLR: begin
        op.we   = 1'b1;
        op.addr = A_INT;
      end
      ST_F101: begin
        op.we   = 1'b1;
        op.addr = A_BUFSEL;
        op.data = 16'(jbuf_q) << 15;
      end
      ST_F107: begin
        op.we   = 1'b1;
        op.addr = A_PGSEC;
        op.data = 16'(jpg_q) << 2;
      end
      ST_F200: begin
        op.we   = 1'b1;
        op.addr = A_BUFSEC;
        op.data = BUFSEC_VAL;
      end
      ST_CMD: begin
        op.we   = 1'b1;
        op.addr = A_CMD;
        op.data = jfin_q ? CMD_FINAL : CMD_CACHE;
      end
      ST_STAT, ST_FSTAT: op.addr = A_STAT;
      ST_FSEL: begin
        op.we   = 1'b1;
        op.addr = A_DIEBLK;
        op.data = 16'(cdie_q) << 15;
      end
      default: ;
    endcase
  end

  assign int_ok = (eng_rdata == INT_READY);
  assign refuse = (|pend) && !(jfin_q && !pend[jdie_q]);

  // next-state logic
  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    cdie_d    = cdie_q;
    jpoll_d   = jpoll_q;
    stat_d    = stat_q;
    load_job  = 1'b0;
    eng_start = 1'b0;
    tmr_clr   = 1'b0;
    tmr_inc   = 1'b0;
    trk_start = 1'b0;
    trk_pend  = 1'b0;
    trk_clr   = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        if (job_valid) begin
          load_job = 1'b1;
          state_d  = S_EVAL;
        end
      end

      S_EVAL: begin
        stat_d  = '0;
        tmr_clr = 1'b1;
        cdie_d  = jdie_q;
        if (jblk_q[0]) begin
          stat_d[ST_ODD] = 1'b1;
          state_d        = S_DONE;
        end else if (refuse) begin
          stat_d[ST_SEQ] = 1'b1;
          state_d        = S_DONE;
        end else begin
          jpoll_d   = started[jdie_q];
          trk_start = 1'b1;
          step_d    = ST_F100;
          state_d   = S_ISSUE;
        end
      end

      S_ISSUE: begin
        eng_start = 1'b1;
        state_d   = S_WAIT;
      end

      S_XFER: begin
        if (xfer_done) begin
          step_d  = ST_CMD;
          state_d = S_ISSUE;
        end
      end

      S_WAIT: begin
        if (eng_done) begin
          state_d = S_ISSUE;
          unique case (step_q)
            ST_F100: step_d = jpoll_q ? ST_POLL : ST_F101;
            ST_POLL, ST_FPOLL: begin
              if (int_ok) begin
                tmr_clr = 1'b1;
                if (step_q == ST_POLL) step_d = auto_clr ? ST_F101 : ST_CLR;
                else                   step_d = auto_clr ? ST_FSTAT : ST_FCLR;
              end else if (tmr_last) begin
                stat_d[ST_TMO] = 1'b1;
                trk_clr        = 1'b1;
                state_d        = S_DONE;
              end else begin
                tmr_inc = 1'b1;
              end
            end
            ST_CLR:  step_d = ST_F101;
            ST_F101: step_d = ST_F107;
            ST_F107: step_d = ST_F200;
            ST_F200: state_d = S_XFER;
            ST_CMD: begin
              if (!jfin_q) begin
                step_d = ST_STAT;
              end else if (|pend) begin
                cdie_d = 1'b0;
                step_d = ST_FSEL;
              end else begin
                trk_pend = 1'b1;
                state_d  = S_DONE;
              end
            end
            ST_STAT: begin
              stat_d[ST_P1] = eng_rdata[4];
              stat_d[ST_P2] = eng_rdata[2];
              state_d       = S_DONE;
            end
            ST_FSEL: begin
              tmr_clr = 1'b1;
              step_d  = ST_FPOLL;
            end
            ST_FCLR: step_d = ST_FSTAT;
            ST_FSTAT: begin
              if (!cdie_q) begin
                stat_d[ST_E0] = eng_rdata[10];
                cdie_d        = 1'b1;
                step_d        = ST_FSEL;
              end else begin
                stat_d[ST_E1] = eng_rdata[10];
                trk_clr       = 1'b1;
                state_d       = S_DONE;
              end
            end
            default: state_d = S_DONE;
          endcase
        end
      end

      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= S_IDLE;
      step_q  <= ST_F100;
      cdie_q  <= 1'b0;
      jpoll_q <= 1'b0;
      stat_q  <= '0;
      jdie_q  <= 1'b0;
      jbuf_q  <= 1'b0;
      jfin_q  <= 1'b0;
      jblk_q  <= '0;
      jpg_q   <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      cdie_q  <= cdie_d;
      jpoll_q <= jpoll_d;
      stat_q  <= stat_d;
      if (load_job) begin
        jdie_q <= job_die;
        jbuf_q <= job_buf;
        jfin_q <= job_final;
        jblk_q <= job_block;
        jpg_q  <= job_page;
      end
    end
  end

  assign job_ready = (state_q == S_IDLE);
  assign xfer_req  = (state_q == S_XFER);
  assign done      = (state_q == S_DONE);
  assign status    = stat_q;
endmodule

// File: rtl/ilv_prog_seq_chk.sv
module ilv_prog_seq_chk
  import ilv_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        job_ready,
  input logic        bus_req,
  input logic        bus_ack,
  input logic        bus_we,
  input logic [15:0] bus_addr,
  input logic [15:0] bus_wdata,
  input logic        xfer_req,
  input logic        done
);
  logic buf_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      buf_seen_q <= 1'b0;
    else if (done)
      buf_seen_q <= 1'b0;
    else if (bus_req && bus_ack && bus_we && bus_addr == A_BUFSEL)
      buf_seen_q <= 1'b1;
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  assert_req_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    job_ready |-> !bus_req && !xfer_req);

  assert_buf_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> buf_seen_q);

  assert_bus_xfer_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && xfer_req));

  assert_cmd_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_addr == A_CMD |-> bus_wdata == CMD_CACHE || bus_wdata == CMD_FINAL);
endmodule

bind ilv_prog_seq ilv_prog_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .job_ready (job_ready),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .xfer_req  (xfer_req),
  .done      (done)
);

// File: tb/tb_ilv_prog_seq.sv
module tb_ilv_prog_seq;
  localparam int BLK_W = 11;
  localparam int PG_W  = 6;
  localparam int PM    = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             auto_clr;
  logic             job_valid, job_ready, job_die, job_buf, job_final;
  logic [BLK_W-1:0] job_block;
  logic [PG_W-1:0]  job_page;
  logic             bus_req, bus_we, bus_ack;
  logic [15:0]      bus_addr, bus_wdata, bus_rdata;
  logic             xfer_req, xfer_done, done;
  logic [6:0]       status;

  ilv_prog_seq #(.BLK_W(BLK_W), .PG_W(PG_W), .POLL_MAX(PM)) dut (
    .clk(clk), .rst_n(rst_n), .auto_clr(auto_clr),
    .job_valid(job_valid), .job_ready(job_ready), .job_die(job_die),
    .job_buf(job_buf), .job_block(job_block), .job_page(job_page),
    .job_final(job_final), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .xfer_req(xfer_req), .xfer_done(xfer_done),
    .done(done), .status(status)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;

  // access log (kind: 0 read, 1 write, 2 transfer)
  logic [1:0]  log_k [0:63];
  logic [15:0] log_a [0:63];
  logic [15:0] log_d [0:63];
  int          log_n;
  logic [1:0]  exp_k [0:63];
  logic [15:0] exp_a [0:63];
  logic [15:0] exp_d [0:63];
  int          exp_n;

  int          nr_left, lat, lat_cnt, xc, stat_idx, hold_bad;
  logic [15:0] stat_vals [0:3];

  // model state
  bit started [0:1];
  int pend_die;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic logit(input logic [1:0] k, input logic [15:0] a, input logic [15:0] d);
    if (log_n < 64) begin
      log_k[log_n] = k; log_a[log_n] = a; log_d[log_n] = d;
    end
    log_n++;
  endtask

  // bus slave with varying latency
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0; lat_cnt = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0;
      if (bus_req) hold_bad++;
    end else if (bus_req) begin
      if (lat_cnt >= lat) begin
        bus_ack = 1'b1;
        lat_cnt = 0;
        lat = (lat + 1) % 3;
        logit({1'b0, bus_we}, bus_addr, bus_we ? bus_wdata : 16'h0000);
        bus_rdata = 16'h0000;
        if (!bus_we && bus_addr == 16'hF241) begin
          if (nr_left > 0) begin bus_rdata = 16'h0040; nr_left--; end
          else bus_rdata = 16'h8040;
        end else if (!bus_we && bus_addr == 16'hF240) begin
          bus_rdata = stat_vals[stat_idx];
          if (stat_idx < 3) stat_idx++;
        end
      end else lat_cnt++;
    end
  end

  // data mover
  always @(negedge clk) begin
    if (!rst_n) begin
      xfer_done = 1'b0; xc = 0;
    end else if (xfer_done) xfer_done = 1'b0;
    else if (xfer_req) begin
      if (xc == 2) begin xfer_done = 1'b1; xc = 0; logit(2'd2, 16'h0, 16'h0); end
      else xc++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
    end
  endtask

  task automatic e(input logic [1:0] k, input logic [15:0] a, input logic [15:0] d);
    exp_k[exp_n] = k; exp_a[exp_n] = a; exp_d[exp_n] = d;
    exp_n++;
  endtask

  task automatic exp_poll(input int nr);
    for (int i = 0; i <= nr; i++) e(2'd0, 16'hF241, 16'h0);
    if (!auto_clr) e(2'd1, 16'hF241, 16'h0);
  endtask

  task automatic run_job(input int die, input int bufs, input int blk, input int pg,
                         input int fin, input int nr, input string tag);
    logic [6:0] exp_st;
    logic [6:0] got_st;
    bit got, poll;
    int nrc;
    exp_n  = 0;
    exp_st = '0;
    if (blk % 2 == 1) exp_st[0] = 1'b1;
    else if (pend_die >= 0 && !(fin == 1 && die != pend_die)) exp_st[1] = 1'b1;
    else begin
      poll = started[die];
      e(2'd1, 16'hF100, 16'((die << 15) + blk));
      if (poll && nr >= PM) begin
        for (int i = 0; i < PM; i++) e(2'd0, 16'hF241, 16'h0);
        exp_st[2] = 1'b1;
        started[0] = 0; started[1] = 0; pend_die = -1;
      end else begin
        if (poll) exp_poll(nr);
        started[die] = 1;
        e(2'd1, 16'hF101, 16'(bufs << 15));
        e(2'd1, 16'hF107, 16'(pg * 4));
        e(2'd1, 16'hF200, 16'h0800);
        e(2'd2, 16'h0, 16'h0);
        e(2'd1, 16'hF220, fin ? 16'h007D : 16'h007F);
        if (!fin) begin
          e(2'd0, 16'hF240, 16'h0);
          exp_st[3] = stat_vals[0][4];
          exp_st[4] = stat_vals[0][2];
        end else if (pend_die >= 0) begin
          nrc = poll ? 0 : nr;
          for (int d = 0; d < 2; d++) begin
            e(2'd1, 16'hF100, 16'(d << 15));
            exp_poll(d == 0 ? nrc : 0);
            e(2'd0, 16'hF240, 16'h0);
          end
          exp_st[5] = stat_vals[0][10];
          exp_st[6] = stat_vals[1][10];
          started[0] = 0; started[1] = 0; pend_die = -1;
        end else pend_die = die;
      end
    end

    nr_left = nr; stat_idx = 0; log_n = 0;
    @(negedge clk);
    while (!job_ready) @(negedge clk);
    job_die = die[0]; job_buf = bufs[0]; job_block = BLK_W'(blk);
    job_page = PG_W'(pg); job_final = fin[0]; job_valid = 1'b1;
    @(negedge clk);
    job_valid = 1'b0;

    got = 0; got_st = '0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (done) begin got = 1; got_st = status; end
    end
    chk(got, tag, "done seen", int'(got), 1);
    if (got) begin
      @(negedge clk);
      chk(!done, "R12", "done width", int'(done), 0);
      begin
        int bad_i;
        bad_i = -1;
        for (int i = 0; i < exp_n && i < log_n; i++)
          if (bad_i < 0 && (log_k[i] != exp_k[i] || log_a[i] != exp_a[i] ||
                            (exp_k[i] == 2'd1 && log_d[i] != exp_d[i]))) bad_i = i;
        if (bad_i < 0 && log_n != exp_n) chk(0, tag, "log length", log_n, exp_n);
        else if (bad_i >= 0)
          chk(0, tag, $sformatf("log[%0d] addr/data", bad_i),
              int'({log_a[bad_i], log_d[bad_i]}), int'({exp_a[bad_i], exp_d[bad_i]}));
        else chk(1, tag, "log", 0, 0);
      end
      chk(got_st == exp_st, tag, "status", int'(got_st), int'(exp_st));
    end
  endtask

  initial begin
    rst_n = 1'b0; auto_clr = 1'b0; job_valid = 1'b0; job_die = 0; job_buf = 0;
    job_block = '0; job_page = '0; job_final = 0; bus_ack = 0; bus_rdata = 0;
    xfer_done = 0; lat = 0; lat_cnt = 0; xc = 0; hold_bad = 0; log_n = 0;
    nr_left = 0; stat_idx = 0;
    for (int i = 0; i < 4; i++) stat_vals[i] = 16'h0;
    started[0] = 0; started[1] = 0; pend_die = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !bus_req && !xfer_req && job_ready, "R1", "reset outputs",
        int'({done, bus_req, xfer_req, job_ready}), 1);

    // cache jobs across dies, buffers, clear modes, plane error bits
    for (int a = 0; a < 2; a++)
      for (int d = 0; d < 2; d++)
        for (int b = 0; b < 2; b++) begin
          auto_clr = a[0];
          stat_vals[0] = 16'((b << 4) | (d << 2));
          run_job(d, b, 2 * (d + 2 * b + 1), a * 4 + d * 2 + b, 0, (d + b) % 3,
                  "R2/R3/R5/R6/R7");
        end

    // final pairs with die error combinations, refusals in between
    for (int a = 0; a < 2; a++)
      for (int ev = 0; ev < 4; ev++) begin
        auto_clr = a[0];
        stat_vals[0] = 16'h0; stat_vals[1] = 16'h0;
        run_job(0, ev % 2, 8 + 2 * ev, ev, 1, 1, "R5/R6 final die0");
        if (ev == 1) begin
          run_job(1, 0, 4, 3, 0, 0, "R8 cache while pending");
          run_job(0, 0, 6, 3, 1, 0, "R8 final same die");
          run_job(1, 0, 5, 3, 1, 0, "R4 odd while pending");
        end
        stat_vals[0] = 16'((ev % 2) << 10); stat_vals[1] = 16'((ev / 2) << 10);
        run_job(1, ev / 2, 20 + 2 * ev, ev + 1, 1, 2, "R9 close");
      end
    run_job(0, 0, 2, 0, 0, 0, "R9 first after close");

    // odd block
    auto_clr = 1'b0;
    run_job(1, 1, 7, 1, 0, 0, "R4 odd");

    // poll timeout boundary
    stat_vals[0] = 16'h0;
    run_job(0, 1, 2, 5, 0, PM - 1, "R6/R10 below limit");
    run_job(0, 1, 2, 6, 0, PM, "R10 timeout");
    run_job(0, 1, 2, 7, 0, 0, "R10 state cleared");

    chk(hold_bad == 0, "R11", "req low after ack", hold_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule